// File: doc/BRIEF.md
# NAND Power-Up Reset and Identification Controller

This block brings a raw NAND device from power-up to a known, identified state before a page sequencer is allowed to use it. When its own reset is released it starts on its own. It sends the device reset command and waits a fixed settling interval. It then polls the device status until both reset-complete bits are set. After that it sends the identification command with a single zero address byte and reads back five identification bytes.

The first two identification bytes are compared against the one supported manufacturer/device pair. The fourth byte is decoded into page size, spare size, block size and bus width. On success the block raises a sticky ready flag and holds the decoded geometry for the page sequencer: page, spare and block sizes in bytes, pages per block, the number of 512-byte ECC chunks, and the block and page address shift amounts. On failure it raises a sticky error flag with a code that tells an unknown part from an unsupported geometry and from a reset that never finished. The bounded wait is optional and is selected by an extended-verification input. The device is reached through the same strobe-level bus as the sequencer: one-cycle command, address and read strobes that share a byte-wide write bus. Read data is sampled in the cycle after a read strobe.

Top module: `nand_probe_ctrl`

## Requirements
- R1: After rst_n is released, the first bus action is a command strobe carrying 0xFF, with no other strobe before it. While rst_n is low, ready and err are 0.
- R2: The first status command (0x70) comes at least FIRST_WAIT cycles and at most FIRST_WAIT+4 cycles after the 0xFF command, where FIRST_WAIT = CLK_KHZ*FIRST_WAIT_US/1000.
- R3: Each status poll is a 0x70 command strobe followed in the next cycle by one read strobe. Reset counts as complete only when status bits 5 and 6 are both 1; a status with only one of them set is treated as busy.
- R4: With ext_verify = 0, polling has no limit and the next status command follows exactly 3 cycles after the previous one.
- R5: With ext_verify = 1, consecutive status commands are between POLL_GAP and POLL_GAP+4 cycles apart, where POLL_GAP = CLK_KHZ*POLL_GAP_US/1000. If POLL_LIMIT = TIMEOUT_US/POLL_GAP_US polls all read busy, no further poll is made and err is raised with err_code 3.
- R6: After reset is complete, the block sends command 0x90, then exactly one address strobe with value 0x00, then exactly five read strobes.
- R7: Only manufacturer byte 0x2C (ID byte 0) together with device byte 0xBA (ID byte 1) is accepted. Any other pair raises err with err_code 1.
- R8: ID byte 3 is the geometry byte. Bits [1:0] select page size 1 KB << code. Bit 2 selects spare per 512 bytes (1 = 16 B, 0 = 8 B). Bits [5:4] select block size 64 KB << code. Bit 6 selects bus width (1 = x16). With STRICT_GEOM = 1, anything other than a 2 KB page, 64-byte spare and 128 KB block raises err with err_code 2. The part check takes precedence.
- R9: On success ready is 1 and err_code 0. The outputs then hold page_bytes 2048, spare_bytes 64, blk_bytes 131072, pages_per_blk 64, ecc_chunks 4, blk_shift 17 and pg_shift 11, with bus_x16 equal to geometry bit 6.
- R10: ready and err are never both 1. Once set, each stays set with its outputs unchanged, and no further bus strobe is issued.
- R11: At most one bus strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; release starts the probe |
| ext_verify | input | 1 | 1 = bounded, spaced status polling; 0 = unbounded polling |
| bus_cmd_stb | output | 1 | One-cycle command strobe, byte on bus_wdata |
| bus_addr_stb | output | 1 | One-cycle address strobe, byte on bus_wdata |
| bus_rd_stb | output | 1 | One-cycle read strobe; data sampled next cycle |
| bus_wdata | output | 8 | Command or address byte |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_rd_stb |
| ready | output | 1 | Sticky success flag |
| err | output | 1 | Sticky failure flag |
| err_code | output | 2 | 0 none, 1 unknown part, 2 bad geometry, 3 reset timeout |
| page_bytes | output | 16 | Page size in bytes |
| spare_bytes | output | 16 | Spare area size in bytes |
| blk_bytes | output | 32 | Block size in bytes |
| pages_per_blk | output | 16 | Pages per block |
| ecc_chunks | output | 5 | Number of 512-byte ECC chunks per page |
| bus_x16 | output | 1 | 1 = 16-bit device bus |
| blk_shift | output | 5 | Block address shift amount |
| pg_shift | output | 5 | Page address shift amount |

## Verification
The assertions check on every cycle that strobes are mutually exclusive and that each status command is followed by its read. They also check that the identification address byte is zero and comes right after the 0x90 command, that ready and err stay sticky and exclusive with no bus traffic after either, that the poll counter stays within its limit, and that a successful result carries the expected geometry. What only the bench scenarios can show is the device-facing timing and decisions. This covers the settling delay and poll spacing in each mode, the exact number of polls before a timeout, and rejection of a status with only one completion bit. It also covers each part-check and geometry failure path with its code, and the bus-width bit.

// File: rtl/nand_probe_pkg.sv
package nand_probe_pkg;

   localparam logic [7:0] CMD_RESET   = 8'hFF;
   localparam logic [7:0] CMD_STATUS  = 8'h70;
   localparam logic [7:0] CMD_READ_ID = 8'h90;
   localparam logic [7:0] STAT_DONE_MASK = 8'h60;
   localparam int ID_LEN = 5;

   typedef enum logic [1:0] {
      PERR_NONE     = 2'd0,
      PERR_NO_PART  = 2'd1,
      PERR_GEOMETRY = 2'd2,
      PERR_TIMEOUT  = 2'd3
   } perr_e;

   typedef struct packed {
      logic [7:0] mfr;
      logic [7:0] dev;
      logic [4:0] blk_shift;
      logic [4:0] pg_shift;
   } part_t;

   localparam part_t KNOWN_PART = '{mfr: 8'h2C, dev: 8'hBA, blk_shift: 5'd17, pg_shift: 5'd11};

   typedef struct packed {
      logic [15:0] page_bytes;
      logic [15:0] spare_bytes;
      logic [31:0] blk_bytes;
      logic [15:0] pages_per_blk;
      logic [4:0]  ecc_chunks;
      logic        x16;
   } geom_t;

endpackage

// File: rtl/nand_probe_timer.sv
module nand_probe_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R2 / R5: a loaded interval counts down one step per cycle
   a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nand_probe_decode.sv
module nand_probe_decode
   import nand_probe_pkg::*;
#(
   parameter bit STRICT_GEOM = 1'b1
) (
   input  logic [7:0] mfr,
   input  logic [7:0] dev,
   input  logic [6:0] geo,
   output logic       part_hit,
   output logic       geo_ok,
   output geom_t      geom
);
   logic [15:0] pg;
   logic [4:0]  chunks;
   logic [3:0]  ppb_sh;

   assign part_hit = (mfr == KNOWN_PART.mfr) && (dev == KNOWN_PART.dev);

   always_comb begin
      pg     = 16'd1024 << geo[1:0];
      chunks = 5'(pg >> 9);
      ppb_sh = 4'd6 + {2'b00, geo[5:4]} - {2'b00, geo[1:0]};
      geom.page_bytes    = pg;
      geom.ecc_chunks    = chunks;
      geom.spare_bytes   = (geo[2] ? 16'd16 : 16'd8) * {11'd0, chunks};
      geom.blk_bytes     = 32'd65536 << geo[5:4];
      geom.pages_per_blk = 16'd1 << ppb_sh;
      geom.x16           = geo[6];
   end

   generate
      if (STRICT_GEOM) begin : g_strict
         assign geo_ok = (geo[1:0] == 2'b01) && geo[2] && (geo[5:4] == 2'b01);
      end else begin : g_any
         assign geo_ok = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/nand_probe_ctrl.sv
module nand_probe_ctrl
   import nand_probe_pkg::*;
#(
   parameter int CLK_KHZ       = 50000,
   parameter int FIRST_WAIT_US = 1000,
   parameter int POLL_GAP_US   = 50,
   parameter int TIMEOUT_US    = 1000000,
   parameter bit STRICT_GEOM   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ext_verify,
   output logic        bus_cmd_stb,
   output logic        bus_addr_stb,
   output logic        bus_rd_stb,
   output logic [7:0]  bus_wdata,
   input  logic [7:0]  bus_rdata,
   output logic        ready,
   output logic        err,
   output logic [1:0]  err_code,
   output logic [15:0] page_bytes,
   output logic [15:0] spare_bytes,
   output logic [31:0] blk_bytes,
   output logic [15:0] pages_per_blk,
   output logic [4:0]  ecc_chunks,
   output logic        bus_x16,
   output logic [4:0]  blk_shift,
   output logic [4:0]  pg_shift
);
   localparam int FIRST_CYC  = int'(longint'(CLK_KHZ) * FIRST_WAIT_US / 1000);
   localparam int GAP_CYC    = int'(longint'(CLK_KHZ) * POLL_GAP_US / 1000);
   localparam int POLL_LIMIT = TIMEOUT_US / POLL_GAP_US;
   localparam int TW         = $clog2(FIRST_CYC + GAP_CYC + 1);
   localparam int FW         = $clog2(POLL_LIMIT + 1);
   localparam int IW         = $clog2(ID_LEN);

   initial begin
      assert (CLK_KHZ > 0 && FIRST_WAIT_US > 0 && POLL_GAP_US > 0);
      assert (POLL_LIMIT >= 1 && GAP_CYC >= 1);
   end

   typedef enum logic [3:0] {
      S_START, S_RST_CMD, S_WAIT, S_ST_CMD, S_ST_RD, S_ST_CAP,
      S_ID_CMD, S_ID_ADDR, S_ID_RD, S_ID_CAP, S_CHECK, S_DONE
   } state_e;

   state_e      st;
   logic [FW-1:0] fails;
   logic [IW-1:0] idx;
   logic [7:0]  mfr_q, dev_q;
   logic [6:0]  geo_q;
   logic        tmr_load, tmr_expired, stat_done;
   logic [TW-1:0] tmr_val;
   logic        part_hit, geo_ok;
   geom_t       geom;

   nand_probe_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired));

   nand_probe_decode #(.STRICT_GEOM(STRICT_GEOM)) u_decode (
      .mfr(mfr_q), .dev(dev_q), .geo(geo_q),
      .part_hit(part_hit), .geo_ok(geo_ok), .geom(geom));

   assign stat_done = ((bus_rdata & STAT_DONE_MASK) == STAT_DONE_MASK);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (st == S_RST_CMD) begin
         tmr_load = 1'b1;
         tmr_val  = TW'(FIRST_CYC);
      end else if (st == S_ST_CAP && !stat_done && ext_verify &&
                   fails != FW'(POLL_LIMIT - 1)) begin
         tmr_load = 1'b1;
         tmr_val  = TW'(GAP_CYC);
      end
   end

   always_comb begin
      bus_cmd_stb  = 1'b0;
      bus_addr_stb = 1'b0;
      bus_rd_stb   = 1'b0;
      bus_wdata    = 8'h00;
      case (st)
         S_RST_CMD: begin bus_cmd_stb = 1'b1; bus_wdata = CMD_RESET;   end
         S_ST_CMD:  begin bus_cmd_stb = 1'b1; bus_wdata = CMD_STATUS;  end
         S_ID_CMD:  begin bus_cmd_stb = 1'b1; bus_wdata = CMD_READ_ID; end
         S_ID_ADDR: bus_addr_stb = 1'b1;
         S_ST_RD, S_ID_RD: bus_rd_stb = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_START;
         fails <= '0;
         idx <= '0;
         mfr_q <= '0; dev_q <= '0; geo_q <= '0;
         ready <= 1'b0; err <= 1'b0; err_code <= PERR_NONE;
         page_bytes <= '0; spare_bytes <= '0; blk_bytes <= '0;
         pages_per_blk <= '0; ecc_chunks <= '0; bus_x16 <= 1'b0;
         blk_shift <= '0; pg_shift <= '0;
      end else begin
         case (st)
            S_START:   st <= S_RST_CMD;
            S_RST_CMD: st <= S_WAIT;
            S_WAIT:    if (tmr_expired) st <= S_ST_CMD;
            S_ST_CMD:  st <= S_ST_RD;
            S_ST_RD:   st <= S_ST_CAP;
            S_ST_CAP: begin
               if (stat_done)        st <= S_ID_CMD;
               else if (!ext_verify) st <= S_ST_CMD;
               else if (fails == FW'(POLL_LIMIT - 1)) begin
                  err      <= 1'b1;
                  err_code <= PERR_TIMEOUT;
                  st       <= S_DONE;
               end else begin
                  fails <= fails + 1'b1;
                  st    <= S_WAIT;
               end
            end
            S_ID_CMD:  st <= S_ID_ADDR;
            S_ID_ADDR: begin idx <= '0; st <= S_ID_RD; end
            S_ID_RD:   st <= S_ID_CAP;
            S_ID_CAP: begin
               case (idx)
                  IW'(0): mfr_q <= bus_rdata;
                  IW'(1): dev_q <= bus_rdata;
                  IW'(3): geo_q <= bus_rdata[6:0];
                  default: ;
               endcase
               if (idx == IW'(ID_LEN - 1)) st <= S_CHECK;
               else begin idx <= idx + 1'b1; st <= S_ID_RD; end
            end
            S_CHECK: begin
               st <= S_DONE;
               if (!part_hit) begin
                  err <= 1'b1; err_code <= PERR_NO_PART;
               end else if (!geo_ok) begin
                  err <= 1'b1; err_code <= PERR_GEOMETRY;
               end else begin
                  ready         <= 1'b1;
                  page_bytes    <= geom.page_bytes;
                  spare_bytes   <= geom.spare_bytes;
                  blk_bytes     <= geom.blk_bytes;
                  pages_per_blk <= geom.pages_per_blk;
                  ecc_chunks    <= geom.ecc_chunks;
                  bus_x16       <= geom.x16;
                  blk_shift     <= KNOWN_PART.blk_shift;
                  pg_shift      <= KNOWN_PART.pg_shift;
               end
            end
            default: st <= S_DONE;
         endcase
      end
   end

   // R11: strobes are exclusive
   a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_cmd_stb, bus_addr_stb, bus_rd_stb}));
   // R3: a status command is followed by its read
   a_r3_status_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_stb && bus_wdata == CMD_STATUS) |=> bus_rd_stb);
   // R6: the single ID address byte is zero and follows the ID command
   a_r6_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_stb |-> (bus_wdata == 8'h00 && $past(bus_cmd_stb) && $past(bus_wdata) == CMD_READ_ID));
   // R5: the failed-poll count never passes its limit
   a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fails <= FW'(POLL_LIMIT - 1));
   // R10: sticky, exclusive flags and a quiet bus after completion
   a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> (ready && !err && $stable(blk_bytes) && $stable(bus_x16)));
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (err && !ready && $stable(err_code)));
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ready || err) |-> !(bus_cmd_stb || bus_addr_stb || bus_rd_stb));
   // R9: a successful strict probe reports the single accepted geometry
   a_r9_geometry: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && STRICT_GEOM) |-> (page_bytes == 16'd2048 && pages_per_blk == 16'd64 &&
                                  spare_bytes == 16'd64 && err_code == 2'd0));

endmodule

// File: tb/nand_probe_ctrl_tb.sv
module nand_probe_ctrl_tb;
   localparam int CLK_KHZ = 1000;
   localparam int FIRST_US = 20;
   localparam int GAP_US = 5;
   localparam int TMO_US = 40;
   localparam int FIRST_WAIT = CLK_KHZ * FIRST_US / 1000;
   localparam int POLL_GAP = CLK_KHZ * GAP_US / 1000;
   localparam int POLL_LIMIT = TMO_US / GAP_US;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_verify = 1'b0;
   logic bus_cmd_stb, bus_addr_stb, bus_rd_stb;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata = 8'h00;
   logic ready, err;
   logic [1:0] err_code;
   logic [15:0] page_bytes, spare_bytes, pages_per_blk;
   logic [31:0] blk_bytes;
   logic [4:0] ecc_chunks, blk_shift, pg_shift;
   logic bus_x16;

   always #10 clk = ~clk;

   nand_probe_ctrl #(.CLK_KHZ(CLK_KHZ), .FIRST_WAIT_US(FIRST_US), .POLL_GAP_US(GAP_US),
                     .TIMEOUT_US(TMO_US), .STRICT_GEOM(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_verify(ext_verify),
      .bus_cmd_stb(bus_cmd_stb), .bus_addr_stb(bus_addr_stb), .bus_rd_stb(bus_rd_stb),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ready(ready), .err(err), .err_code(err_code),
      .page_bytes(page_bytes), .spare_bytes(spare_bytes), .blk_bytes(blk_bytes),
      .pages_per_blk(pages_per_blk), .ecc_chunks(ecc_chunks), .bus_x16(bus_x16),
      .blk_shift(blk_shift), .pg_shift(pg_shift));

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // device model configuration
   logic [7:0] id_b [5];
   int busy_polls = 0;
   logic [7:0] busy_val = 8'h00;
   logic [7:0] done_val = 8'h60;

   // bus monitor state
   int cyc = 0;
   int n_any, n_rst, n_stat, n_idcmd, n_addr, n_idrd, n_after, n_multi;
   int t_rst, t_first_st, t_last_st, min_gap, max_gap, st_reads, id_idx;
   logic [7:0] first_cmd, last_cmd, addr_val;

   task automatic clear_mon();
      n_any = 0; n_rst = 0; n_stat = 0; n_idcmd = 0; n_addr = 0; n_idrd = 0;
      n_after = 0; n_multi = 0; t_rst = 0; t_first_st = 0; t_last_st = 0;
      min_gap = 1000000; max_gap = 0; st_reads = 0; id_idx = 0;
      first_cmd = 8'h00; last_cmd = 8'h00; addr_val = 8'hAA;
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if ((int'(bus_cmd_stb) + int'(bus_addr_stb) + int'(bus_rd_stb)) > 1) n_multi = n_multi + 1;
         if ((ready || err) && (bus_cmd_stb || bus_addr_stb || bus_rd_stb)) n_after = n_after + 1;
         if (bus_cmd_stb) begin
            if (n_any == 0) first_cmd = bus_wdata;
            last_cmd = bus_wdata;
            if (bus_wdata == 8'hFF) begin n_rst = n_rst + 1; t_rst = cyc; end
            if (bus_wdata == 8'h70) begin
               if (n_stat == 0) t_first_st = cyc;
               else begin
                  if (cyc - t_last_st < min_gap) min_gap = cyc - t_last_st;
                  if (cyc - t_last_st > max_gap) max_gap = cyc - t_last_st;
               end
               t_last_st = cyc;
               n_stat = n_stat + 1;
            end
            if (bus_wdata == 8'h90) begin n_idcmd = n_idcmd + 1; id_idx = 0; end
         end
         if (bus_addr_stb) begin n_addr = n_addr + 1; addr_val = bus_wdata; end
         if (bus_rd_stb) begin
            if (last_cmd == 8'h70) begin
               bus_rdata <= (st_reads < busy_polls) ? busy_val : done_val;
               st_reads = st_reads + 1;
            end else begin
               bus_rdata <= (id_idx < 5) ? id_b[id_idx] : 8'hEE;
               id_idx = id_idx + 1;
               n_idrd = n_idrd + 1;
            end
         end
         if (bus_cmd_stb || bus_addr_stb || bus_rd_stb) n_any = n_any + 1;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks = checks + 1;
      if (act != exp) begin
         failures = failures + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(input bit ext, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b3, input int busy, input logic [7:0] bval,
                      input int max_cyc);
      @(negedge clk);
      rst_n = 1'b0;
      ext_verify = ext;
      id_b[0] = b0; id_b[1] = b1; id_b[2] = 8'h00; id_b[3] = b3; id_b[4] = 8'h00;
      busy_polls = busy; busy_val = bval; done_val = 8'h60;
      repeat (3) @(negedge clk);
      clear_mon();
      rst_n = 1'b1;
      begin
         int n = 0;
         while (!(ready || err) && n < max_cyc) begin @(negedge clk); n = n + 1; end
      end
      repeat (20) @(negedge clk);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", ready, 0);
      chk("R1 err in reset", err, 0);
   endtask

   task automatic t_good_normal();
      run(1'b0, 8'h2C, 8'hBA, 8'h55, 3, 8'h00, 3000);
      chk("R1 first command", first_cmd, 8'hFF);
      chk("R1 one reset command", n_rst, 1);
      chk("R2 settle min", longint'(t_first_st - t_rst >= FIRST_WAIT), 1);
      chk("R2 settle max", longint'(t_first_st - t_rst <= FIRST_WAIT + 4), 1);
      chk("R3 polls until done", n_stat, 4);
      chk("R4 back-to-back spacing min", min_gap, 3);
      chk("R4 back-to-back spacing max", max_gap, 3);
      chk("R6 id command", n_idcmd, 1);
      chk("R6 one address", n_addr, 1);
      chk("R6 address zero", addr_val, 0);
      chk("R6 five reads", n_idrd, 5);
      chk("R9 ready", ready, 1);
      chk("R9 err_code", err_code, 0);
      chk("R9 page", page_bytes, 2048);
      chk("R9 spare", spare_bytes, 64);
      chk("R9 block", blk_bytes, 131072);
      chk("R9 ppb", pages_per_blk, 64);
      chk("R9 ecc", ecc_chunks, 4);
      chk("R9 blk shift", blk_shift, 17);
      chk("R9 pg shift", pg_shift, 11);
      chk("R9 x16", bus_x16, 1);
      chk("R10 quiet after ready", n_after, 0);
      chk("R10 exclusive", err, 0);
      chk("R11 single strobe", n_multi, 0);
   endtask

   task automatic t_good_x8();
      run(1'b0, 8'h2C, 8'hBA, 8'h15, 0, 8'h00, 3000);
      chk("R9 x8 ready", ready, 1);
      chk("R9 x8 width", bus_x16, 0);
      chk("R3 single poll", n_stat, 1);
   endtask

   task automatic t_half_status();
      // status 0x40 (bit 6 only) twice, then 0x20 seen as busy too
      run(1'b0, 8'h2C, 8'hBA, 8'h55, 2, 8'h40, 3000);
      chk("R3 bit6 alone is busy", n_stat, 3);
      run(1'b1, 8'h2C, 8'hBA, 8'h55, 1000, 8'h20, 3000);
      chk("R3 bit5 alone never completes", err_code, 3);
      chk("R3 no id after bit5 only", n_idcmd, 0);
   endtask

   task automatic t_ext_timeout();
      run(1'b1, 8'h2C, 8'hBA, 8'h55, 1000, 8'h00, 3000);
      chk("R5 err", err, 1);
      chk("R5 code", err_code, 3);
      chk("R5 poll count", n_stat, POLL_LIMIT);
      chk("R5 gap min", longint'(min_gap >= POLL_GAP), 1);
      chk("R5 gap max", longint'(max_gap <= POLL_GAP + 4), 1);
      chk("R10 no ready on err", ready, 0);
      chk("R10 quiet after err", n_after, 0);
   endtask

   task automatic t_ext_success();
      run(1'b1, 8'h2C, 8'hBA, 8'h55, 3, 8'h00, 3000);
      chk("R5 success before limit", ready, 1);
      chk("R5 polls", n_stat, 4);
      chk("R5 spaced", longint'(min_gap >= POLL_GAP), 1);
   endtask

   task automatic t_parts();
      run(1'b0, 8'h2D, 8'hBA, 8'h55, 0, 8'h00, 3000);
      chk("R7 bad mfr code", err_code, 1);
      chk("R7 bad mfr err", err, 1);
      run(1'b0, 8'h2C, 8'hBB, 8'h55, 0, 8'h00, 3000);
      chk("R7 bad dev code", err_code, 1);
      run(1'b0, 8'h2C, 8'hBA, 8'h56, 0, 8'h00, 3000);
      chk("R8 page 4K rejected", err_code, 2);
      run(1'b0, 8'h2C, 8'hBA, 8'h51, 0, 8'h00, 3000);
      chk("R8 spare 8B rejected", err_code, 2);
      run(1'b0, 8'h2C, 8'hBA, 8'h65, 0, 8'h00, 3000);
      chk("R8 block 256K rejected", err_code, 2);
      chk("R8 no ready", ready, 0);
      run(1'b0, 8'h11, 8'h22, 8'h65, 0, 8'h00, 3000);
      chk("R8 part check first", err_code, 1);
   endtask

   initial begin
      clear_mon();
      t_reset_state();
      t_good_normal();
      t_good_x8();
      t_half_status();
      t_ext_timeout();
      t_ext_success();
      t_parts();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks = checks + 1;
         failures = failures + 1;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule